// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block selects, for each of the two ALU operands entering the execute stage of a five-stage pipeline, where the operand value comes from. The register file value latched in the decode/execute register is the default. A result that is still in flight in a later stage can be taken instead. One later stage is the execute/memory register, which holds an ALU result. The other is the memory/write-back register, which holds the final value being written: either an ALU result or loaded data.

The unit is purely combinational. Each operand's source index is compared against the destination index and write enable of both later stages. The unit drives a 2-bit select and the chosen operand value. When both later stages target the operand's register, the newer execute/memory result wins, so that two consecutive writers of one register followed by a reader deliver the latest value. Register index zero is never forwarded. Load-use stalling and the pipeline registers themselves sit outside this block.

Top module: `exe_fwd_unit`

## Requirements
- R1: When the execute/memory write enable is 1, its destination is nonzero and it equals an operand's source index, that operand's select is 2'b10 and its value is the execute/memory data.
- R2: When the write-back write enable is 1, its destination is nonzero and equals the source index, and R1 does not apply to that operand, the select is 2'b01 and the value is the write-back data.
- R3: When both later stages would match the same operand, the execute/memory result is chosen (select 2'b10).
- R4: A destination index of zero is never forwarded, even with its write enable set.
- R5: A stage whose write enable is 0 is never forwarded from, even when its destination matches.
- R6: When neither stage matches, the select is 2'b00 and the operand equals the register file value from the decode/execute register.
- R7: Operand A and operand B are resolved independently of each other.
- R8: Outputs are a combinational function of the current inputs, with no clock and no state.
- R9: A select value of 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx_i | input | IDX_W | Operand A source register index |
| src_b_idx_i | input | IDX_W | Operand B source register index |
| rf_a_data_i | input | DATA_W | Operand A value read from the register file |
| rf_b_data_i | input | DATA_W | Operand B value read from the register file |
| exm_we_i | input | 1 | Execute/memory stage writes a register |
| exm_rd_i | input | IDX_W | Execute/memory destination index |
| exm_data_i | input | DATA_W | Execute/memory ALU result |
| wb_we_i | input | 1 | Write-back stage writes a register |
| wb_rd_i | input | IDX_W | Write-back destination index |
| wb_data_i | input | DATA_W | Final write-back value |
| sel_a_o | output | 2 | Operand A source select |
| sel_b_o | output | 2 | Operand B source select |
| op_a_o | output | DATA_W | Resolved operand A |
| op_b_o | output | DATA_W | Resolved operand B |

## Verification
The block holds no state, so a wrong match or priority shows up at the select and operand ports in the same evaluation that the inputs change. No error can hide for a later cycle. Any priority mistake shows as a stale write-back value when a register has two writers in flight. A missing zero or enable qualifier shows as a forwarded value where the register file value was due. Random vectors with a small index space make these collisions frequent. Directed vectors pin the two-writer case and the index-zero case.

// File: rtl/exe_fwd_pkg.sv
package exe_fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int IDX_W = 3
) (
  input  logic             we_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [IDX_W-1:0] src_i,
  output logic             hit_o
);
  always_comb hit_o = we_i && (dst_i != '0) && (dst_i == src_i);
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
  import exe_fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0]  src_i,
  input  logic [DATA_W-1:0] rf_data_i,
  input  logic              exm_we_i,
  input  logic [IDX_W-1:0]  exm_rd_i,
  input  logic [DATA_W-1:0] exm_data_i,
  input  logic              wb_we_i,
  input  logic [IDX_W-1:0]  wb_rd_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic [1:0]        sel_o,
  output logic [DATA_W-1:0] op_o
);
  logic exm_hit, wb_hit;
  fwd_sel_e sel;

  fwd_match #(.IDX_W(IDX_W)) i_exm_match (
    .we_i(exm_we_i), .dst_i(exm_rd_i), .src_i(src_i), .hit_o(exm_hit)
  );
  fwd_match #(.IDX_W(IDX_W)) i_wb_match (
    .we_i(wb_we_i), .dst_i(wb_rd_i), .src_i(src_i), .hit_o(wb_hit)
  );

  // newer stage first
  always_comb begin
    if (exm_hit)     sel = FWD_EXM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  always_comb begin
    unique case (sel)
      FWD_EXM: op_o = exm_data_i;
      FWD_WB:  op_o = wb_data_i;
      default: op_o = rf_data_i;
    endcase
  end

  assign sel_o = sel;

  always_comb begin
    a_r9_sel_legal: assert (sel_o != 2'b11);
    // R3: both stages matching must pick execute/memory
    a_r3_exm_first: assert (!(exm_hit && wb_hit) || sel_o == 2'b10);
    a_r4_zero_idx: assert (src_i != '0 || sel_o == 2'b00);
    a_r5_we_low: assert ((exm_we_i || sel_o != 2'b10) && (wb_we_i || sel_o != 2'b01));
    a_r1_exm_data: assert (sel_o != 2'b10 || op_o == exm_data_i);
    a_r2_wb_data: assert (sel_o != 2'b01 || op_o == wb_data_i);
    a_r6_pass: assert (exm_hit || wb_hit || op_o == rf_data_i);
  end
endmodule

// File: rtl/exe_fwd_unit.sv
module exe_fwd_unit #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0]  src_a_idx_i,
  input  logic [IDX_W-1:0]  src_b_idx_i,
  input  logic [DATA_W-1:0] rf_a_data_i,
  input  logic [DATA_W-1:0] rf_b_data_i,
  input  logic              exm_we_i,
  input  logic [IDX_W-1:0]  exm_rd_i,
  input  logic [DATA_W-1:0] exm_data_i,
  input  logic              wb_we_i,
  input  logic [IDX_W-1:0]  wb_rd_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o
);
  localparam int NUM_OPS = 2;

  logic [IDX_W-1:0]  src_idx [NUM_OPS];
  logic [DATA_W-1:0] rf_data [NUM_OPS];
  logic [1:0]        sel     [NUM_OPS];
  logic [DATA_W-1:0] op      [NUM_OPS];

  assign src_idx[0] = src_a_idx_i;
  assign src_idx[1] = src_b_idx_i;
  assign rf_data[0] = rf_a_data_i;
  assign rf_data[1] = rf_b_data_i;

  // R7: one independent selector per operand
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_operand #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_operand (
      .src_i     (src_idx[g]),
      .rf_data_i (rf_data[g]),
      .exm_we_i  (exm_we_i),
      .exm_rd_i  (exm_rd_i),
      .exm_data_i(exm_data_i),
      .wb_we_i   (wb_we_i),
      .wb_rd_i   (wb_rd_i),
      .wb_data_i (wb_data_i),
      .sel_o     (sel[g]),
      .op_o      (op[g])
    );
  end

  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];
  assign op_a_o  = op[0];
  assign op_b_o  = op[1];
endmodule

// File: tb/test_exe_fwd_unit.sv
module test_exe_fwd_unit;
  localparam int DW = 32;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [IW-1:0] src_a, src_b, exm_rd, wb_rd;
  logic [DW-1:0] rf_a, rf_b, exm_d, wb_d;
  logic exm_we, wb_we;
  logic [1:0] sel_a, sel_b;
  logic [DW-1:0] op_a, op_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  exe_fwd_unit #(.DATA_W(DW), .IDX_W(IW)) i_exe_fwd_unit (
    .src_a_idx_i(src_a), .src_b_idx_i(src_b),
    .rf_a_data_i(rf_a), .rf_b_data_i(rf_b),
    .exm_we_i(exm_we), .exm_rd_i(exm_rd), .exm_data_i(exm_d),
    .wb_we_i(wb_we), .wb_rd_i(wb_rd), .wb_data_i(wb_d),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .op_a_o(op_a), .op_b_o(op_b)
  );

  // behavioural reference: newest writer of the register wins, r0 never forwarded
  task automatic ref_op(input int src, input logic [DW-1:0] rf,
                        output logic [1:0] s, output logic [DW-1:0] d, output string tag);
    bit e_ok, w_ok;
    e_ok = exm_we && (int'(exm_rd) == src) && src != 0;
    w_ok = wb_we && (int'(wb_rd) == src) && src != 0;
    s = 2'b00; d = rf; tag = "R6";
    if (src == 0 && ((exm_we && exm_rd == 0) || (wb_we && wb_rd == 0))) tag = "R4";
    else if (!exm_we && int'(exm_rd) == src || !wb_we && int'(wb_rd) == src) tag = "R5";
    if (w_ok) begin s = 2'b01; d = wb_d; tag = "R2"; end
    if (e_ok) begin s = 2'b10; d = exm_d; tag = w_ok ? "R3" : "R1"; end
  endtask

  task automatic check_now(input string extra);
    logic [1:0] s; logic [DW-1:0] d; string t;
    ref_op(int'(src_a), rf_a, s, d, t);
    n_vec++;
    if (sel_a !== s || op_a !== d) begin
      n_bad++;
      $display("FAIL %s/%s R7 operand A: sel=%b op=%h expected sel=%b op=%h", t, extra, sel_a, op_a, s, d);
    end
    ref_op(int'(src_b), rf_b, s, d, t);
    n_vec++;
    if (sel_b !== s || op_b !== d) begin
      n_bad++;
      $display("FAIL %s/%s R7 operand B: sel=%b op=%h expected sel=%b op=%h", t, extra, sel_b, op_b, s, d);
    end
    n_vec++;
    if (sel_a === 2'b11 || sel_b === 2'b11) begin
      n_bad++;
      $display("FAIL R9 select 11: sel_a=%b sel_b=%b expected not 11", sel_a, sel_b);
    end
  endtask

  task automatic apply(input int sa, input int sb, input bit ew, input int er,
                       input bit ww, input int wr, input string tag);
    @(posedge clk);
    src_a = IW'(sa); src_b = IW'(sb);
    exm_we = ew; exm_rd = IW'(er); wb_we = ww; wb_rd = IW'(wr);
    rf_a = 32'hA000_0000 + DW'(sa); rf_b = 32'hB000_0000 + DW'(sb);
    exm_d = 32'hE000_0000 + DW'(er); wb_d = 32'h5000_0000 + DW'(wr);
    @(negedge clk);
    check_now(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    src_a = '0; src_b = '0; exm_rd = '0; wb_rd = '0;
    exm_we = 0; wb_we = 0; rf_a = 1; rf_b = 2; exm_d = 3; wb_d = 4;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    apply(1, 2, 0, 0, 0, 0, "R6 idle");            // R6
    apply(3, 4, 1, 3, 0, 0, "R1 A from exm");      // R1
    apply(3, 4, 0, 0, 1, 4, "R2 B from wb");       // R2
    apply(1, 1, 1, 1, 1, 1, "R3 two writers r1");  // R3
    apply(5, 5, 1, 2, 1, 5, "R2 exm miss");        // R2
    apply(0, 0, 1, 0, 1, 0, "R4 r0");              // R4
    apply(6, 6, 0, 6, 0, 6, "R5 we low");          // R5
    apply(2, 7, 1, 2, 1, 7, "R7 split");           // R7
    apply(7, 2, 1, 2, 1, 7, "R7 swapped");         // R7
    // R8: change data between edges, outputs follow with no clock
    @(posedge clk);
    #1 exm_d = 32'h1234_5678;
    #1 check_now("R8 no clock");
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      src_a = IW'($urandom); src_b = IW'($urandom);
      exm_we = 1'($urandom); wb_we = 1'($urandom);
      exm_rd = IW'($urandom); wb_rd = IW'($urandom);
      rf_a = $urandom; rf_b = $urandom; exm_d = $urandom; wb_d = $urandom;
      @(negedge clk);
      check_now("random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule